// File: doc/BRIEF.md
# Banked Address Map Decoder

This block sits between an 8-bit processor's 16-bit bus and the memories and peripherals behind it. It holds a 6-bit I/O port and a matching direction register, both on the bus at the two lowest addresses. From these it derives a 3-bit bank configuration, and that configuration decides whether the upper windows of the address space show RAM, one of three ROMs, or the I/O page. For every bus cycle it registers a one-hot target select, a target-local offset, a write qualifier and the write data. It then returns read data through a mux fed by the targets' read buses.

The I/O page is split into a video block, a sound block, a 1K x 4 colour memory, two timer blocks and an expansion register block. An unmapped open-bus stretch returns a fixed pattern. An identification window at the top of the page holds a constant signature byte and a byte that flips between 55h and AAh on each read. Writes never land in ROM: when a ROM is mapped over RAM, a write goes to the RAM underneath.

A two-state sequencer tracks the bus cycle. PH_IDLE moves to PH_ACCESS on the capture transition, which is a strobed bus cycle. PH_ACCESS stays in PH_ACCESS on another capture. It returns to PH_IDLE on the retire transition, which is a clock with no strobe.

Top module: `bank_decoder`

## Requirements
- R1: After reset the direction register and the port register both hold 0. `valid_o` is 0 and `sel_o` is all zero. A read of address 0000h returns 00h.
- R2: A write to 0000h sets the direction register and a write to 0001h sets the port register. Each register keeps the low 6 bits of the data, and a read of the same address returns them with bits 7:6 at 0. The bank configuration is bits 2:0 of (NOT direction) OR port, and it applies from the next bus cycle onward.
- R3: A read in A000h–BFFFh selects BASIC ROM (sel bit 1, offset addr[12:0]) only when configuration bits 1:0 are both 1. Otherwise it selects RAM (sel bit 0, offset = full address).
- R4: A read in E000h–FFFFh selects KERNAL ROM (sel bit 2, offset addr[12:0]) whenever configuration bit 1 is 1. Otherwise it selects RAM.
- R5: In D000h–DFFFh, reads see the character ROM (sel bit 3, offset addr[11:0]) when configuration bits 1:0 are nonzero and bit 2 is 0. They see the I/O page when bits 1:0 are nonzero and bit 2 is 1. They see RAM when bits 1:0 are 00.
- R6: In the I/O page, addr[11:8] selects the device. Values 0–3 select video (sel bit 4, offset addr[5:0]). Values 4–7 select sound (bit 5, addr[4:0]). Values 8–B select colour memory (bit 6, addr[9:0]). C selects timer 1 (bit 7, addr[3:0]) and D selects timer 2 (bit 8, addr[3:0]). Read data comes from that device's read bus.
- R7: In the I/O page, DF00h–DF0Fh selects the expansion block (bit 9, addr[3:0]). A read elsewhere in DE00h–DF9Fh selects open bus (bit 11) and returns OPEN_VAL (default FFh).
- R8: A colour memory write drives `wdata_o` with bits 7:4 cleared. A colour read returns {OPEN_VAL[7:4], color_rd}.
- R9: Writes below D000h, writes at E000h and above, and writes in D000h–DFFFh while the I/O page is not mapped all select RAM, even when a ROM is mapped there. A write to the I/O page's ID window or open-bus area selects nothing.
- R10: A read in DFA0h–DFFFh with I/O mapped selects the ID window (bit 10, offset addr[6:0]). DFFEh returns 46h. DFFFh returns AAh on the first read after reset and then alternates 55h/AAh with each read. Other ID addresses return OPEN_VAL. Writes do not advance the toggle.
- R11: All decode outputs are registered. `valid_o`, `sel_o`, `off_o`, `wr_o` and `wdata_o` describe the access strobed at the previous clock edge. With no strobe at an edge, `valid_o` and `sel_o` drop to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_strobe | input | 1 | Bus cycle present this clock |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| ram_rd | input | 8 | RAM read data |
| basic_rd | input | 8 | BASIC ROM read data |
| kernal_rd | input | 8 | KERNAL ROM read data |
| char_rd | input | 8 | Character ROM read data |
| video_rd | input | 8 | Video block read data |
| sound_rd | input | 8 | Sound block read data |
| color_rd | input | 4 | Colour memory read data |
| timer1_rd | input | 8 | Timer 1 read data |
| timer2_rd | input | 8 | Timer 2 read data |
| expn_rd | input | 8 | Expansion block read data |
| valid_o | output | 1 | Registered access valid |
| sel_o | output | 13 | One-hot target (bit 12 = port registers) |
| off_o | output | 16 | Target-local offset |
| wr_o | output | 1 | Registered write qualifier |
| wdata_o | output | 8 | Registered write data |
| rdata_o | output | 8 | Read data for the registered access |

## Verification
The bench walks the port through the configurations 000, 001, 010, 011, 100, 101 and 111. At each step it probes the A000h, D000h and E000h windows, so every ROM enable is seen both on and off and configuration bit 2 is seen both with and without bits 1:0. Under 111 it reads each I/O device at a low and a high register address, which separates the device boundaries and the offset masks. Repeated DFFFh reads, with a write in between, tell a real per-read toggle from a constant or from a write-driven toggle. Writes under ROM and into the ID and open-bus areas show that writes fall through to RAM or select nothing.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
    localparam int ADDR_W = 16;
    localparam int PORT_W = 6;
    localparam int CFG_W  = 3;

    typedef enum logic [3:0] {
        T_RAM    = 4'd0,
        T_BASIC  = 4'd1,
        T_KERNAL = 4'd2,
        T_CHAR   = 4'd3,
        T_VIDEO  = 4'd4,
        T_SOUND  = 4'd5,
        T_COLOR  = 4'd6,
        T_TIMER1 = 4'd7,
        T_TIMER2 = 4'd8,
        T_EXPN   = 4'd9,
        T_IDWIN  = 4'd10,
        T_OPEN   = 4'd11,
        T_PORT   = 4'd12,
        T_NONE   = 4'd13
    } tgt_e;

    localparam int N_TGT = 13;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACCESS = 1'b1
    } phase_e;
endpackage

// File: rtl/bdec_port_regs.sv
module bdec_port_regs
    import bdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              which,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] port_q,
    output logic [CFG_W-1:0]  cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            port_q <= '0;
        end else if (wr_en) begin
            if (which) port_q <= wdata;
            else       dir_q  <= wdata;
        end
    end

    logic [PORT_W-1:0] eff;
    assign eff = ~dir_q | port_q;
    assign cfg = eff[CFG_W-1:0];

    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_q) && $stable(port_q))); // R2
endmodule

// File: rtl/bdec_map.sv
module bdec_map
    import bdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [CFG_W-1:0]  cfg,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] off
);
    logic basic_on, kern_on, char_on, io_on;
    assign basic_on = (cfg[1:0] == 2'b11);
    assign kern_on  = cfg[1];
    assign char_on  = (|cfg[1:0]) && !cfg[2];
    assign io_on    = (|cfg[1:0]) && cfg[2];

    logic [3:0] top_nib;
    assign top_nib = addr[15:12];

    always_comb begin
        tgt = T_NONE;
        off = '0;
        if (top_nib == 4'hD && io_on) begin
            unique case (addr[11:8])
                4'h0, 4'h1, 4'h2, 4'h3: begin tgt = T_VIDEO;  off = {10'd0, addr[5:0]}; end
                4'h4, 4'h5, 4'h6, 4'h7: begin tgt = T_SOUND;  off = {11'd0, addr[4:0]}; end
                4'h8, 4'h9, 4'hA, 4'hB: begin tgt = T_COLOR;  off = {6'd0, addr[9:0]}; end
                4'hC:                   begin tgt = T_TIMER1; off = {12'd0, addr[3:0]}; end
                4'hD:                   begin tgt = T_TIMER2; off = {12'd0, addr[3:0]}; end
                default: begin
                    if (addr[15:4] == 12'hDF0) begin
                        tgt = T_EXPN; off = {12'd0, addr[3:0]};
                    end else if (!we && addr < 16'hDFA0) begin
                        tgt = T_OPEN;
                    end else if (!we) begin
                        tgt = T_IDWIN; off = {9'd0, addr[6:0]};
                    end
                end
            endcase
        end else if (we) begin
            tgt = T_RAM; off = addr;
        end else if (addr[15:1] == '0) begin
            tgt = T_PORT; off = addr;
        end else if ((top_nib == 4'hA || top_nib == 4'hB) && basic_on) begin
            tgt = T_BASIC; off = {3'd0, addr[12:0]};
        end else if (top_nib == 4'hD && char_on) begin
            tgt = T_CHAR; off = {4'd0, addr[11:0]};
        end else if ((top_nib == 4'hE || top_nib == 4'hF) && kern_on) begin
            tgt = T_KERNAL; off = {3'd0, addr[12:0]};
        end else begin
            tgt = T_RAM; off = addr;
        end
    end
endmodule

// File: rtl/bdec_id_window.sv
module bdec_id_window #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  SIG_BYTE = 8'h46,
    parameter logic [7:0]  TOG_INIT = 8'h55,
    parameter logic [7:0]  OPEN_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    input  logic [6:0]        ofs,
    output logic [DATA_W-1:0] id_data
);
    logic [DATA_W-1:0] tog_q;

    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= TOG_INIT;
        else if (bump) tog_q <= ~tog_q;
    end

    always_comb begin
        if (ofs == 7'h7F)      id_data = tog_q;
        else if (ofs == 7'h7E) id_data = SIG_BYTE;
        else                   id_data = OPEN_VAL;
    end

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (tog_q == ~$past(tog_q))); // R10
    AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(tog_q)); // R10
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
    import bdec_pkg::*;
#(
    parameter int         DATA_W   = 8,
    parameter int         COL_W    = 4,
    parameter logic [7:0] OPEN_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_strobe,
    input  logic              bus_we,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [7:0]        ram_rd,
    input  logic [7:0]        basic_rd,
    input  logic [7:0]        kernal_rd,
    input  logic [7:0]        char_rd,
    input  logic [7:0]        video_rd,
    input  logic [7:0]        sound_rd,
    input  logic [3:0]        color_rd,
    input  logic [7:0]        timer1_rd,
    input  logic [7:0]        timer2_rd,
    input  logic [7:0]        expn_rd,
    output logic              valid_o,
    output logic [12:0]       sel_o,
    output logic [15:0]       off_o,
    output logic              wr_o,
    output logic [7:0]        wdata_o,
    output logic [7:0]        rdata_o
);
    localparam int HI_W = DATA_W - COL_W;

    logic [PORT_W-1:0] dir_q, port_q;
    logic [CFG_W-1:0]  cfg;
    tgt_e              tgt_d, tgt_q;
    logic [ADDR_W-1:0] off_d, off_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q, id_data;
    phase_e            state_q, state_d;

    logic port_wr, id_bump;
    assign port_wr = bus_strobe && bus_we && (bus_addr[15:1] == '0);
    assign id_bump = bus_strobe && !bus_we && (tgt_d == T_IDWIN) && (bus_addr[6:0] == 7'h7F);

    bdec_port_regs u_port (
        .clk(clk), .rst_n(rst_n), .wr_en(port_wr), .which(bus_addr[0]),
        .wdata(bus_wdata[PORT_W-1:0]), .dir_q(dir_q), .port_q(port_q), .cfg(cfg)
    );

    bdec_map u_map (
        .addr(bus_addr), .we(bus_we), .cfg(cfg), .tgt(tgt_d), .off(off_d)
    );

    bdec_id_window #(.DATA_W(DATA_W), .OPEN_VAL(OPEN_VAL)) u_id (
        .clk(clk), .rst_n(rst_n), .bump(id_bump), .ofs(off_q[6:0]), .id_data(id_data)
    );

    // sequencer: next state
    always_comb begin
        unique case (state_q)
            PH_IDLE:   state_d = bus_strobe ? PH_ACCESS : PH_IDLE;
            PH_ACCESS: state_d = bus_strobe ? PH_ACCESS : PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    // state and access registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            tgt_q   <= T_NONE;
            off_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (bus_strobe) begin
                tgt_q   <= tgt_d;
                off_q   <= off_d;
                wr_q    <= bus_we;
                wdata_q <= (tgt_d == T_COLOR) ? {{HI_W{1'b0}}, bus_wdata[COL_W-1:0]} : bus_wdata;
            end
        end
    end

    // outputs
    assign valid_o = (state_q == PH_ACCESS);
    assign off_o   = off_q;
    assign wr_o    = valid_o && wr_q;
    assign wdata_o = wdata_q;

    for (genvar i = 0; i < N_TGT; i++) begin : g_sel
        assign sel_o[i] = valid_o && (tgt_q == tgt_e'(i));
    end

    always_comb begin
        rdata_o = OPEN_VAL;
        if (valid_o && !wr_q) begin
            unique case (tgt_q)
                T_RAM:    rdata_o = ram_rd;
                T_BASIC:  rdata_o = basic_rd;
                T_KERNAL: rdata_o = kernal_rd;
                T_CHAR:   rdata_o = char_rd;
                T_VIDEO:  rdata_o = video_rd;
                T_SOUND:  rdata_o = sound_rd;
                T_COLOR:  rdata_o = {OPEN_VAL[DATA_W-1:COL_W], color_rd};
                T_TIMER1: rdata_o = timer1_rd;
                T_TIMER2: rdata_o = timer2_rd;
                T_EXPN:   rdata_o = expn_rd;
                T_IDWIN:  rdata_o = id_data;
                T_PORT:   rdata_o = {2'b00, off_q[0] ? port_q : dir_q};
                default:  rdata_o = OPEN_VAL;
            endcase
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> valid_o); // R11
    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> (sel_o == '0)); // R11
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !wr_o |-> $onehot(sel_o)); // R11
    AST_NO_ROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> !(sel_o[T_BASIC] || sel_o[T_KERNAL] || sel_o[T_CHAR])); // R9
    AST_KERNAL_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (!sel_o[T_KERNAL] || $past(cfg[1]))); // R4
    AST_BASIC_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> (!sel_o[T_BASIC] || ($past(cfg[1:0]) == 2'b11))); // R3
    AST_COLOR_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && sel_o[T_COLOR]) |-> (wdata_o[7:4] == 4'h0)); // R8
endmodule

// File: tb/tb_bank_decoder.sv
module tb_bank_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NONE = -1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_strobe = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        valid_o, wr_o;
    logic [12:0] sel_o;
    logic [15:0] off_o;
    logic [7:0]  wdata_o, rdata_o;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_decoder dut (
        .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ram_rd(8'h11), .basic_rd(8'h22), .kernal_rd(8'h33), .char_rd(8'h44),
        .video_rd(8'h66), .sound_rd(8'h77), .color_rd(4'h9),
        .timer1_rd(8'h88), .timer2_rd(8'h99), .expn_rd(8'hAB),
        .valid_o(valid_o), .sel_o(sel_o), .off_o(off_o), .wr_o(wr_o),
        .wdata_o(wdata_o), .rdata_o(rdata_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one strobed cycle; results sampled after the capturing edge
    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; bus_strobe = 1'b1;
        @(negedge clk);
        bus_strobe = 1'b0;
    endtask

    task automatic rd(input string req, input logic [15:0] a, input int idx,
                      input logic [15:0] off, input logic [7:0] data);
        access(1'b0, a, 8'h00);
        chk(req, $sformatf("sel @%h", a), {19'd0, sel_o}, (idx < 0) ? 32'd0 : (32'd1 << idx));
        chk(req, $sformatf("off @%h", a), {16'd0, off_o}, {16'd0, off});
        chk(req, $sformatf("rdata @%h", a), {24'd0, rdata_o}, {24'd0, data});
    endtask

    task automatic wr(input string req, input logic [15:0] a, input logic [7:0] d,
                      input int idx, input logic [7:0] wexp);
        access(1'b1, a, d);
        chk(req, $sformatf("wsel @%h", a), {19'd0, sel_o}, (idx < 0) ? 32'd0 : (32'd1 << idx));
        chk(req, $sformatf("wr_o @%h", a), {31'd0, wr_o}, 32'd1);
        if (idx >= 0) chk(req, $sformatf("wdata @%h", a), {24'd0, wdata_o}, {24'd0, wexp});
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "valid after reset", {31'd0, valid_o}, 32'd0);
        chk("R1", "sel after reset", {19'd0, sel_o}, 32'd0);
        rd("R1", 16'h0000, 12, 16'h0000, 8'h00);
        rd("R1", 16'h0001, 12, 16'h0001, 8'h00);
    endtask

    task automatic t_timing();
        access(1'b0, 16'hC000, 8'h00);
        chk("R11", "valid after strobe", {31'd0, valid_o}, 32'd1);
        @(negedge clk);
        chk("R11", "valid after idle", {31'd0, valid_o}, 32'd0);
        chk("R11", "sel after idle", {19'd0, sel_o}, 32'd0);
    endtask

    task automatic t_port_regs();
        wr("R2", 16'h0000, 8'hFF, 0, 8'hFF);
        rd("R2", 16'h0000, 12, 16'h0000, 8'h3F);
        wr("R2", 16'h0001, 8'hC2, 0, 8'hC2);
        rd("R2", 16'h0001, 12, 16'h0001, 8'h02);
    endtask

    task automatic set_cfg(input logic [2:0] c);
        wr("R2", 16'h0000, 8'h07, 0, 8'h07);
        wr("R2", 16'h0001, {5'd0, c}, 0, {5'd0, c});
    endtask

    task automatic t_banks();
        // reset config is 111
        rd("R3", 16'hA000, 1, 16'h0000, 8'h22);
        rd("R4", 16'hE123, 2, 16'h0123, 8'h33);
        rd("R5", 16'hD020, 4, 16'h0020, 8'h66);
        set_cfg(3'b000);
        rd("R3", 16'hA000, 0, 16'hA000, 8'h11);
        rd("R4", 16'hE000, 0, 16'hE000, 8'h11);
        rd("R5", 16'hD000, 0, 16'hD000, 8'h11);
        set_cfg(3'b001);
        rd("R5", 16'hD123, 3, 16'h0123, 8'h44);
        rd("R3", 16'hB000, 0, 16'hB000, 8'h11);
        rd("R4", 16'hF000, 0, 16'hF000, 8'h11);
        set_cfg(3'b010);
        rd("R4", 16'hFFFC, 2, 16'h1FFC, 8'h33);
        rd("R3", 16'hA000, 0, 16'hA000, 8'h11);
        set_cfg(3'b011);
        rd("R3", 16'hBFFF, 1, 16'h1FFF, 8'h22);
        rd("R5", 16'hDFFF, 3, 16'h0FFF, 8'h44);
        set_cfg(3'b100);
        rd("R5", 16'hD400, 0, 16'hD400, 8'h11);
        set_cfg(3'b101);
        rd("R5", 16'hD400, 5, 16'h0000, 8'h77);
        rd("R4", 16'hE000, 0, 16'hE000, 8'h11);
        rd("R3", 16'hA000, 0, 16'hA000, 8'h11);
    endtask

    task automatic t_io();
        set_cfg(3'b111);
        rd("R6", 16'hD3FF, 4, 16'h003F, 8'h66);
        rd("R6", 16'hD7FF, 5, 16'h001F, 8'h77);
        rd("R8", 16'hD800, 6, 16'h0000, 8'hF9);
        rd("R6", 16'hDBFF, 6, 16'h03FF, 8'hF9);
        rd("R6", 16'hDCFF, 7, 16'h000F, 8'h88);
        rd("R6", 16'hDD05, 8, 16'h0005, 8'h99);
        rd("R7", 16'hDF05, 9, 16'h0005, 8'hAB);
        rd("R7", 16'hDE00, 11, 16'h0000, 8'hFF);
        rd("R7", 16'hDF9F, 11, 16'h0000, 8'hFF);
    endtask

    task automatic t_idwin();
        rd("R10", 16'hDFFE, 10, 16'h007E, 8'h46);
        rd("R10", 16'hDFFF, 10, 16'h007F, 8'hAA);
        rd("R10", 16'hDFFF, 10, 16'h007F, 8'h55);
        rd("R10", 16'hDFA0, 10, 16'h0020, 8'hFF);
        wr("R10", 16'hDFFF, 8'h00, NONE, 8'h00);
        rd("R10", 16'hDFFF, 10, 16'h007F, 8'hAA);
    endtask

    task automatic t_writes();
        wr("R8", 16'hD800, 8'hF5, 6, 8'h05);
        wr("R9", 16'hA000, 8'h5A, 0, 8'h5A);
        wr("R9", 16'hE000, 8'h3C, 0, 8'h3C);
        wr("R9", 16'hDE00, 8'h12, NONE, 8'h00);
        wr("R6", 16'hD020, 8'h0E, 4, 8'h0E);
        set_cfg(3'b001);
        wr("R9", 16'hD000, 8'h77, 0, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_banks();
        t_io();
        t_idwin();
        t_writes();
        t_port_regs();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule